// File: doc/BRIEF.md
# Dual-Clock Scan-Out Pixel Framebuffer

This block is a small video peripheral. It keeps a low-resolution picture, three colour bits per cell, in an internal dual-port store and streams it to a VGA monitor. A processor writes single cells on its own clock. Each write gives a row, a column and a colour. The colour is either a literal carried in the instruction or the bottom three bits of the processor's working register, and a select input picks between them on every write. Writes whose row or column lies outside the picture are dropped.

The display side runs on an independent pixel clock. Its horizontal and vertical counters produce 640x480 frame timing with active-low sync pulses. Every stored cell is blown up into a square of 2^SCALE_LOG2 by 2^SCALE_LOG2 screen pixels, so the default 120x160 picture fills the screen. The store is read with one cycle of latency, and the sync and blanking flags are delayed to match. The colour outputs are held at zero whenever the beam is outside the visible area.

After the write-side reset is released, the block first sweeps the whole store and fills it with a constant background colour. Processor writes are accepted once that sweep has finished.

Top module: `pixel_fb_top`

## Requirements
- R1: While the pixel-side reset is asserted, hsync_n and vsync_n are 1 and red, green and blue are 0.
- R2: Once write-side reset is released, and after ROWS*ceil(COLS/LANES) write clocks, every visible pixel shows INIT_COLOR until a cell is written.
- R3: When pix_we=1 and use_wreg=0 on a write-clock edge with row_idx<ROWS and col_idx<COLS, the cell takes lit_color. It is shown on every screen pixel whose line/2^SCALE_LOG2 equals the row and whose column/2^SCALE_LOG2 equals the column.
- R4: Under the same conditions with use_wreg=1, the cell takes wreg_low and lit_color is not used.
- R5: A cell colour c appears as red=c[2], green=c[1], blue=c[0].
- R6: A write with row_idx>=ROWS or col_idx>=COLS changes no cell.
- R7: Each line lasts H_VIS+H_FP+H_SYNC+H_BP pixel clocks, with H_VIS=COLS*2^SCALE_LOG2. hsync_n is 0 for H_SYNC clocks, starting H_VIS+H_FP clocks after the line's first visible pixel.
- R8: Each frame lasts V_VIS+V_FP+V_SYNC+V_BP lines, with V_VIS=ROWS*2^SCALE_LOG2. vsync_n is 0 during lines V_VIS+V_FP to V_VIS+V_FP+V_SYNC-1.
- R9: red, green and blue are 0 on every pixel clock outside the visible area.
- R10: Writing one cell never changes another cell that sits in the same storage word (cells with the same row and the same col_idx/LANES).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Processor (write) clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low; its release starts the background fill |
| pix_we | input | 1 | Cell write strobe |
| row_idx | input | ROW_W | Row of the cell to write |
| col_idx | input | COL_W | Column of the cell to write |
| use_wreg | input | 1 | 0: colour from lit_color, 1: colour from wreg_low |
| lit_color | input | 3 | Literal colour from the instruction |
| wreg_low | input | 3 | Three least significant working-register bits |
| pclk | input | 1 | Pixel clock |
| prst_n | input | 1 | Pixel-side asynchronous reset, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 1 | Red pixel bit |
| green | output | 1 | Green pixel bit |
| blue | output | 1 | Blue pixel bit |

## Verification
The hardest cases to reach from the ports are the ones where writes land in storage words shared with other cells. Two of them matter most: neighbouring cells in one packed word, and an out-of-range column that would alias into the first word of the next row if it were not rejected. A full frame at the default geometry is also far too long to check every pixel. The bench therefore shrinks the geometry through parameters, so a whole frame, including vertical sync, fits in a few thousand pixel clocks. It aims directed writes at lane neighbours and at aliasing out-of-range indices, then adds seeded random writes. After each group of writes it compares every output on every pixel clock of a complete frame against its own model of the picture.

// File: rtl/vfb_pkg.sv
package vfb_pkg;

  typedef logic [2:0] rgb3_t;

  typedef enum logic {
    SRC_LITERAL = 1'b0,
    SRC_WORKREG = 1'b1
  } color_src_e;

  // storage word holding cell (r, c) when each word packs `lanes` cells
  function automatic int unsigned cell_word(int unsigned r, int unsigned c,
                                            int unsigned wpr, int unsigned lanes);
    return r * wpr + c / lanes;
  endfunction

  // position of column c inside its storage word
  function automatic int unsigned cell_lane(int unsigned c, int unsigned lanes);
    return c % lanes;
  endfunction

  // screen counter to cell index under power-of-two magnification
  function automatic int unsigned cell_of_count(int unsigned cnt, int unsigned sl);
    return cnt >> sl;
  endfunction

  // true when x lies in [lo, lo+len)
  function automatic logic in_window(int unsigned x, int unsigned lo, int unsigned len);
    return (x >= lo) && (x < lo + len);
  endfunction

endpackage

// File: rtl/vfb_timing.sv
module vfb_timing #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int HC_W   = $clog2(H_VIS + H_FP + H_SYNC + H_BP),
  parameter int VC_W   = $clog2(V_VIS + V_FP + V_SYNC + V_BP)
) (
  input  logic            pclk,
  input  logic            prst_n,
  output logic [HC_W-1:0] hcnt,
  output logic [VC_W-1:0] vcnt,
  output logic            visible,
  output logic            hs_act,
  output logic            vs_act
);
  import vfb_pkg::*;

  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;

  logic h_last, v_last;

  assign h_last = (int'(hcnt) == H_TOT - 1);
  assign v_last = (int'(vcnt) == V_TOT - 1);

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_last) begin
      hcnt <= '0;
      vcnt <= v_last ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign visible = (int'(hcnt) < H_VIS) && (int'(vcnt) < V_VIS);
  assign hs_act  = in_window(int'(hcnt), H_VIS + H_FP, H_SYNC);
  assign vs_act  = in_window(int'(vcnt), V_VIS + V_FP, V_SYNC);

  // R7: a line ends by returning the column counter to zero
  a_r7_line_wrap: assert property (@(posedge pclk) disable iff (!prst_n)
    h_last |=> (hcnt == '0));

  // R8: the line counter steps by one at the end of each non-final line
  a_r8_line_step: assert property (@(posedge pclk) disable iff (!prst_n)
    (h_last && !v_last) |=> (vcnt == $past(vcnt) + 1'b1));

  // R7: a sync pulse, once started, lasts more than one clock
  a_r7_hsync_hold: assert property (@(posedge pclk) disable iff (!prst_n)
    $rose(hs_act) |=> hs_act);

endmodule

// File: rtl/vfb_wport.sv
module vfb_wport #(
  parameter int ROWS   = 120,
  parameter int COLS   = 160,
  parameter int LANES  = 16,
  parameter int WPR    = (COLS + LANES - 1) / LANES,
  parameter int WORDS  = ROWS * WPR,
  parameter int ADDR_W = $clog2(WORDS),
  parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  parameter int ROW_W  = $clog2(ROWS + 1),
  parameter int COL_W  = $clog2(COLS + 1)
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              pix_we,
  input  logic [ROW_W-1:0]  row_idx,
  input  logic [COL_W-1:0]  col_idx,
  input  logic              use_wreg,
  input  logic [2:0]        lit_color,
  input  logic [2:0]        wreg_low,
  output logic              mem_we,
  output logic              mem_fill,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANE_W-1:0] mem_lane,
  output logic [2:0]        mem_color
);
  import vfb_pkg::*;

  logic              filling;
  logic [ADDR_W-1:0] fill_ptr;
  logic              in_range;
  color_src_e        src;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      filling  <= 1'b1;
      fill_ptr <= '0;
    end else if (filling) begin
      if (int'(fill_ptr) == WORDS - 1) filling <= 1'b0;
      else                             fill_ptr <= fill_ptr + 1'b1;
    end
  end

  assign in_range  = (int'(row_idx) < ROWS) && (int'(col_idx) < COLS);
  assign src       = color_src_e'(use_wreg);
  assign mem_fill  = filling;
  assign mem_we    = pix_we && !filling && in_range;
  assign mem_addr  = filling ? fill_ptr
                             : ADDR_W'(cell_word(int'(row_idx), int'(col_idx), WPR, LANES));
  assign mem_lane  = LANE_W'(cell_lane(int'(col_idx), LANES));
  assign mem_color = (src == SRC_WORKREG) ? wreg_low : lit_color;

  // R2: the background fill runs once and never restarts without reset
  a_r2_fill_once: assert property (@(posedge wclk) disable iff (!wrst_n)
    !filling |=> !filling);

  // R6: no store write ever lands outside the store
  a_r6_addr_bound: assert property (@(posedge wclk) disable iff (!wrst_n)
    (mem_we || mem_fill) |-> (int'(mem_addr) < WORDS));

endmodule

// File: rtl/vfb_store.sv
module vfb_store #(
  parameter int         WORDS      = 1200,
  parameter int         LANES      = 16,
  parameter int         ADDR_W     = $clog2(WORDS),
  parameter int         LANE_W     = (LANES > 1) ? $clog2(LANES) : 1,
  parameter logic [2:0] INIT_COLOR = 3'b001
) (
  input  logic                 wclk,
  input  logic                 we,
  input  logic                 fill,
  input  logic [ADDR_W-1:0]    waddr,
  input  logic [LANE_W-1:0]    wlane,
  input  logic [2:0]           wcolor,
  input  logic                 pclk,
  input  logic [ADDR_W-1:0]    raddr,
  output logic [LANES*3-1:0]   rword
);

  logic [LANES*3-1:0] mem [WORDS];

  // fill writes a whole word; a cell write touches one 3-bit lane
  always_ff @(posedge wclk) begin
    if (fill)    mem[waddr] <= {LANES{INIT_COLOR}};
    else if (we) mem[waddr][int'(wlane)*3 +: 3] <= wcolor;
  end

  always_ff @(posedge pclk) begin
    rword <= mem[raddr];
  end

endmodule

// File: rtl/pixel_fb_top.sv
module pixel_fb_top #(
  parameter int         ROWS       = 120,
  parameter int         COLS       = 160,
  parameter int         SCALE_LOG2 = 2,
  parameter int         LANES      = 16,
  parameter int         H_FP       = 16,
  parameter int         H_SYNC     = 96,
  parameter int         H_BP       = 48,
  parameter int         V_FP       = 10,
  parameter int         V_SYNC     = 2,
  parameter int         V_BP       = 33,
  parameter logic [2:0] INIT_COLOR = 3'b001,
  localparam int        ROW_W      = $clog2(ROWS + 1),
  localparam int        COL_W      = $clog2(COLS + 1)
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic             pix_we,
  input  logic [ROW_W-1:0] row_idx,
  input  logic [COL_W-1:0] col_idx,
  input  logic             use_wreg,
  input  logic [2:0]       lit_color,
  input  logic [2:0]       wreg_low,
  input  logic             pclk,
  input  logic             prst_n,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             red,
  output logic             green,
  output logic             blue
);
  import vfb_pkg::*;

  localparam int H_VIS  = COLS << SCALE_LOG2;
  localparam int V_VIS  = ROWS << SCALE_LOG2;
  localparam int HC_W   = $clog2(H_VIS + H_FP + H_SYNC + H_BP);
  localparam int VC_W   = $clog2(V_VIS + V_FP + V_SYNC + V_BP);
  localparam int WPR    = (COLS + LANES - 1) / LANES;
  localparam int WORDS  = ROWS * WPR;
  localparam int ADDR_W = $clog2(WORDS);
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

  // write side
  logic              mem_we, mem_fill;
  logic [ADDR_W-1:0] mem_addr;
  logic [LANE_W-1:0] mem_lane;
  logic [2:0]        mem_color;

  vfb_wport #(
    .ROWS(ROWS), .COLS(COLS), .LANES(LANES), .WPR(WPR), .WORDS(WORDS),
    .ADDR_W(ADDR_W), .LANE_W(LANE_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) wport_i (
    .wclk(wclk), .wrst_n(wrst_n), .pix_we(pix_we),
    .row_idx(row_idx), .col_idx(col_idx), .use_wreg(use_wreg),
    .lit_color(lit_color), .wreg_low(wreg_low),
    .mem_we(mem_we), .mem_fill(mem_fill), .mem_addr(mem_addr),
    .mem_lane(mem_lane), .mem_color(mem_color)
  );

  // display timing
  logic [HC_W-1:0] hcnt;
  logic [VC_W-1:0] vcnt;
  logic            visible, hs_act, vs_act;

  vfb_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HC_W(HC_W), .VC_W(VC_W)
  ) timing_i (
    .pclk(pclk), .prst_n(prst_n), .hcnt(hcnt), .vcnt(vcnt),
    .visible(visible), .hs_act(hs_act), .vs_act(vs_act)
  );

  // read address; blanked positions read word 0 so the index stays in range
  logic [ADDR_W-1:0] rd_addr;
  logic [LANE_W-1:0] rd_lane;
  int unsigned       cell_r, cell_c;

  assign cell_r  = cell_of_count(int'(vcnt), SCALE_LOG2);
  assign cell_c  = cell_of_count(int'(hcnt), SCALE_LOG2);
  assign rd_addr = visible ? ADDR_W'(cell_word(cell_r, cell_c, WPR, LANES)) : '0;
  assign rd_lane = LANE_W'(cell_lane(cell_c, LANES));

  logic [LANES*3-1:0] rd_word;

  vfb_store #(
    .WORDS(WORDS), .LANES(LANES), .ADDR_W(ADDR_W), .LANE_W(LANE_W),
    .INIT_COLOR(INIT_COLOR)
  ) store_i (
    .wclk(wclk), .we(mem_we), .fill(mem_fill), .waddr(mem_addr),
    .wlane(mem_lane), .wcolor(mem_color),
    .pclk(pclk), .raddr(rd_addr), .rword(rd_word)
  );

  // stage 1: control flags travel alongside the store read
  logic              vis_q, hs_q, vs_q;
  logic [LANE_W-1:0] lane_q;

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      vis_q  <= 1'b0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      lane_q <= '0;
    end else begin
      vis_q  <= visible;
      hs_q   <= hs_act;
      vs_q   <= vs_act;
      lane_q <= rd_lane;
    end
  end

  // stage 2: registered outputs
  rgb3_t cell_rgb;
  assign cell_rgb = rd_word[int'(lane_q)*3 +: 3];

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      red     <= 1'b0;
      green   <= 1'b0;
      blue    <= 1'b0;
    end else begin
      hsync_n <= !hs_q;
      vsync_n <= !vs_q;
      red     <= vis_q && cell_rgb[2];
      green   <= vis_q && cell_rgb[1];
      blue    <= vis_q && cell_rgb[0];
    end
  end

  // R9: sync periods lie inside blanking, so colour must be dark there
  a_r9_dark_in_sync: assert property (@(posedge pclk) disable iff (!prst_n)
    (!hsync_n || !vsync_n) |-> ({red, green, blue} == 3'b000));

  // R8: a vertical sync pulse spans whole lines, never a single clock
  a_r8_vsync_hold: assert property (@(posedge pclk) disable iff (!prst_n)
    $fell(vsync_n) |=> !vsync_n);

endmodule

// File: tb/pixel_fb_top_tb.sv
module pixel_fb_top_tb_top;

  localparam int         ROWS   = 6;
  localparam int         COLS   = 24;
  localparam int         SL     = 2;
  localparam int         LANES  = 8;
  localparam int         H_FP   = 8;
  localparam int         H_SYNC = 12;
  localparam int         H_BP   = 8;
  localparam int         V_FP   = 2;
  localparam int         V_SYNC = 2;
  localparam int         V_BP   = 3;
  localparam logic [2:0] INIT_C = 3'b001;

  localparam int H_VIS = COLS << SL;
  localparam int V_VIS = ROWS << SL;
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int FRAME = H_TOT * V_TOT;
  localparam int WORDS = ROWS * ((COLS + LANES - 1) / LANES);
  localparam int ROW_W = $clog2(ROWS + 1);
  localparam int COL_W = $clog2(COLS + 1);

  logic             wclk = 1'b0, pclk = 1'b0;
  logic             wrst_n = 1'b0, prst_n = 1'b0;
  logic             pix_we = 1'b0, use_wreg = 1'b0;
  logic [ROW_W-1:0] row_idx = '0;
  logic [COL_W-1:0] col_idx = '0;
  logic [2:0]       lit_color = '0, wreg_low = '0;
  logic             hsync_n, vsync_n, red, green, blue;

  always #4 wclk = ~wclk;   // 125 MHz write clock
  always #6 pclk = ~pclk;   // independent pixel clock

  pixel_fb_top #(
    .ROWS(ROWS), .COLS(COLS), .SCALE_LOG2(SL), .LANES(LANES),
    .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP), .INIT_COLOR(INIT_C)
  ) dut_i (
    .wclk(wclk), .wrst_n(wrst_n), .pix_we(pix_we),
    .row_idx(row_idx), .col_idx(col_idx), .use_wreg(use_wreg),
    .lit_color(lit_color), .wreg_low(wreg_low),
    .pclk(pclk), .prst_n(prst_n),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .red(red), .green(green), .blue(blue)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    ecount = 0;
  logic [2:0] img [ROWS][COLS];
  string      tag [ROWS][COLS];

  always @(posedge pclk) begin
    if (!prst_n) ecount <= 0;
    else         ecount <= ecount + 1;
  end

  // outputs after edge n describe counter position n-2
  function automatic int pos_now();
    return (ecount - 2) % FRAME;
  endfunction

  function automatic logic exp_hs_n(int h);
    return !((h >= H_VIS + H_FP) && (h < H_VIS + H_FP + H_SYNC));
  endfunction

  function automatic logic exp_vs_n(int v);
    return !((v >= V_VIS + V_FP) && (v < V_VIS + V_FP + V_SYNC));
  endfunction

  task automatic set_all_tags(string t);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) tag[r][c] = t;
  endtask

  task automatic wr(int r, int c, logic sel, logic [2:0] lit, logic [2:0] wl, string t);
    @(negedge wclk);
    row_idx   = ROW_W'(r);
    col_idx   = COL_W'(c);
    use_wreg  = sel;
    lit_color = lit;
    wreg_low  = wl;
    pix_we    = 1'b1;
    @(negedge wclk);
    pix_we    = 1'b0;
    if (r < ROWS && c < COLS) begin
      img[r][c] = sel ? wl : lit;
      tag[r][c] = t;
    end
  endtask

  // compare every output on every pixel clock of one complete frame
  task automatic check_frame();
    repeat (4) @(negedge pclk);
    do @(negedge pclk); while (pos_now() != 0);
    for (int k = 0; k < FRAME; k++) begin
      int h, v;
      logic vis, ehs, evs;
      logic [2:0] ergb;
      string t;
      if (k != 0) @(negedge pclk);
      h    = pos_now() % H_TOT;
      v    = pos_now() / H_TOT;
      vis  = (h < H_VIS) && (v < V_VIS);
      ehs  = exp_hs_n(h);
      evs  = exp_vs_n(v);
      ergb = vis ? img[v >> SL][h >> SL] : 3'b000;
      t    = vis ? tag[v >> SL][h >> SL] : "R9";
      n_chk++;
      if (hsync_n !== ehs) begin
        n_bad++;
        $display("FAIL R7 h=%0d v=%0d hsync_n got %b exp %b", h, v, hsync_n, ehs);
      end else if (vsync_n !== evs) begin
        n_bad++;
        $display("FAIL R8 h=%0d v=%0d vsync_n got %b exp %b", h, v, vsync_n, evs);
      end else if ({red, green, blue} !== ergb) begin
        n_bad++;
        $display("FAIL %s (R5 bit order) h=%0d v=%0d rgb got %b exp %b",
                 t, h, v, {red, green, blue}, ergb);
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge wclk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'h0005EED5);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) img[r][c] = INIT_C;
    set_all_tags("R2");

    // R1: idle levels during reset
    repeat (3) begin
      @(negedge pclk);
      n_chk++;
      if ({hsync_n, vsync_n, red, green, blue} !== 5'b11000) begin
        n_bad++;
        $display("FAIL R1 reset outputs got %b exp %b",
                 {hsync_n, vsync_n, red, green, blue}, 5'b11000);
      end
    end
    @(negedge wclk) wrst_n = 1'b1;
    @(negedge pclk) prst_n = 1'b1;
    repeat (WORDS + 4) @(negedge wclk);

    // R2: background fill everywhere; R7/R8/R9 timing throughout
    check_frame();

    // R6: out-of-range rows and columns, incl. indices aliasing into the next row
    set_all_tags("R6");
    wr(ROWS, 0, 1'b0, 3'b111, 3'b000, "R6");
    wr((1 << ROW_W) - 1, (1 << COL_W) - 1, 1'b0, 3'b110, 3'b000, "R6");
    wr(0, COLS, 1'b0, 3'b100, 3'b000, "R6");
    wr(2, COLS + 6, 1'b1, 3'b000, 3'b111, "R6");
    wr(ROWS - 1, COLS, 1'b0, 3'b010, 3'b000, "R6");
    check_frame();

    // R5: one colour channel per cell
    wr(0, 0, 1'b0, 3'b100, 3'b011, "R5");
    wr(0, 1, 1'b0, 3'b010, 3'b101, "R5");
    wr(0, 2, 1'b0, 3'b001, 3'b110, "R5");
    // R3: literal into the far corner
    wr(ROWS - 1, COLS - 1, 1'b0, 3'b111, 3'b000, "R3");
    // R4: working-register source, literal differs
    wr(2, 5, 1'b1, 3'b001, 3'b110, "R4");
    wr(4, 12, 1'b1, 3'b111, 3'b000, "R4");
    // R10: neighbours inside one storage word and across a word edge
    wr(3, LANES - 1, 1'b0, 3'b101, 3'b000, "R10");
    wr(3, LANES, 1'b0, 3'b010, 3'b000, "R10");
    wr(3, LANES - 2, 1'b0, 3'b110, 3'b000, "R10");
    wr(3, LANES - 1, 1'b1, 3'b000, 3'b011, "R10");
    check_frame();

    // R3/R4: seeded random writes
    for (int i = 0; i < 60; i++) begin
      int r, c;
      logic s;
      r = int'($urandom_range(ROWS - 1, 0));
      c = int'($urandom_range(COLS - 1, 0));
      s = 1'($urandom_range(1, 0));
      wr(r, c, s, 3'($urandom_range(7, 0)), 3'($urandom_range(7, 0)), s ? "R4" : "R3");
    end
    check_frame();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule